// File: doc/BRIEF.md
# Boundary Output Drive Selector

This block sits between the boundary-scan update latches and the output pads of a chip. For every output pin it decides two things: which data bit reaches the pad, and whether the pad driver is enabled. The data bit is either the functional value from the core or the value held in the scan cell. The choice depends on the test instruction currently in force and on whether scan chain 0 is the selected chain. The block also raises an external indicator whenever the instruction forces every output to high impedance.

The instruction arrives as a set of decoded flags from the instruction register's update stage. The chain-0 flag comes from the chain-select register. Both are already latched elsewhere. This block is therefore purely combinational, so the pads move only when one of those latched values, or the data feeding the pins, changes. Scan shifting, capture and the TAP state machine belong to neighbouring logic.

Pins are counted by the parameter `NUM_PINS`. The parameter `TRISTATE_MASK` marks which pins have three-state drivers (bit i = 1 means pin i can be switched off by the quiet-clamp instruction). With defaults, pins 0 to 6 are three-state and pin 7 is not. All ports are plain level signals; no handshake applies.

Top module: `bsc_out_ctrl`

## Requirements
- R1: With `ir_extest` = 1 and no higher-priority mode active, every pin takes `pin_data[i]` = `cell_data[i]` and `pin_oe[i]` = `cell_oe[i]`, whatever the value of `chain0_sel`.
- R2: When no instruction flag that alters the pins is active, including when only `ir_preload` = 1 (the sample/preload, identification and bypass cases), `pin_data` = `func_data` and `pin_oe` = `func_oe`; preloaded cell values do not reach the pads.
- R3: With `ir_clamp` = 1 and `chain0_sel` = 1, `pin_data` = `cell_data` and `pin_oe` = `cell_oe`.
- R4: With `ir_highz` = 1 and `chain0_sel` = 1, every bit of `pin_oe` is 0, `pin_data` = `func_data` and `highz_ind` = 1.
- R5: With `ir_clampz` = 1 and `chain0_sel` = 1, `pin_data` = `cell_data`; `pin_oe[i]` = 0 for every pin whose `TRISTATE_MASK` bit is 1, and `pin_oe[i]` = `cell_oe[i]` for the others.
- R6: With `chain0_sel` = 0, the flags `ir_clamp`, `ir_highz` and `ir_clampz` have no effect on the pins: outputs follow R1 if `ir_extest` = 1, otherwise R2.
- R7: `highz_ind` is 0 in every case except `ir_highz` = 1 together with `chain0_sel` = 1.
- R8: When several flags are set at once, the first match wins in this order: high-Z with chain 0, quiet clamp with chain 0, clamp with chain 0, external test, functional.
- R9: The outputs are a combinational function of the inputs: a change of any input appears at the pins without waiting for a clock edge, and with the inputs held the pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_extest | input | 1 | External-test instruction active |
| ir_preload | input | 1 | Sample/preload instruction active |
| ir_clamp | input | 1 | Clamp instruction active |
| ir_highz | input | 1 | All-outputs-off instruction active |
| ir_clampz | input | 1 | Quiet-clamp instruction active |
| chain0_sel | input | 1 | Scan chain 0 is the selected chain |
| func_data | input | NUM_PINS | Functional data from the core |
| func_oe | input | NUM_PINS | Functional driver enables from the core |
| cell_data | input | NUM_PINS | Data held in the scan update latches |
| cell_oe | input | NUM_PINS | Enables held in the scan update latches |
| pin_data | output | NUM_PINS | Data to the output pads |
| pin_oe | output | NUM_PINS | Driver enables to the output pads |
| highz_ind | output | 1 | External all-outputs-off indicator |

## Verification
The two functions that can fall in the same cycle are the chain-0 gating of the clamp family and the external-test path. A chain-select update can land while an instruction flag is already held, and several decode flags can be raised together. The bench raises external test together with clamp and toggles `chain0_sel` under it. It also raises high-Z, quiet clamp, clamp and external test at once. Each combination is judged against the priority order of R8 and the gating of R6, pin by pin, with the indicator checked in the same sample.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // How a pin is driven after instruction and chain decode.
  typedef enum logic [1:0] {
    DRV_FUNC       = 2'd0,  // core data and core enable
    DRV_SCAN       = 2'd1,  // cell data and cell enable
    DRV_SCAN_QUIET = 2'd2,  // cell data, three-state drivers off
    DRV_ALL_OFF    = 2'd3   // every driver off
  } drv_mode_e;

endpackage

// File: rtl/bsc_mode_decode.sv
module bsc_mode_decode
  import bsc_pkg::*;
(
  input  logic      ir_extest,
  input  logic      ir_clamp,
  input  logic      ir_highz,
  input  logic      ir_clampz,
  input  logic      chain0_sel,
  output drv_mode_e mode,
  output logic      highz_ind
);

  // Priority chain: the clamp family is honoured only on chain 0.
  always_comb begin
    if (chain0_sel && ir_highz)       mode = DRV_ALL_OFF;
    else if (chain0_sel && ir_clampz) mode = DRV_SCAN_QUIET;
    else if (chain0_sel && ir_clamp)  mode = DRV_SCAN;
    else if (ir_extest)               mode = DRV_SCAN;
    else                              mode = DRV_FUNC;
  end

  assign highz_ind = (mode == DRV_ALL_OFF);

  // Chain gating: without chain 0 the quiet and off modes never appear (R6).
  always_comb begin
    if (!chain0_sel)
      p_no_clamp_off_chain_r6: assert (mode == DRV_FUNC || mode == DRV_SCAN)
        else $error("mode %0d without chain 0", mode);
  end

endmodule

// File: rtl/bsc_pin_ctrl.sv
module bsc_pin_ctrl
  import bsc_pkg::*;
#(
  parameter bit TRISTATE = 1'b1
) (
  input  drv_mode_e mode,
  input  logic      func_d,
  input  logic      func_oe,
  input  logic      cell_d,
  input  logic      cell_oe,
  output logic      pin_d,
  output logic      pin_oe
);

  logic quiet_oe;

  // A two-state driver cannot be turned off by the quiet clamp.
  generate
    if (TRISTATE) begin : g_tri
      assign quiet_oe = 1'b0;
    end else begin : g_two
      assign quiet_oe = cell_oe;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      DRV_SCAN: begin
        pin_d  = cell_d;
        pin_oe = cell_oe;
      end
      DRV_SCAN_QUIET: begin
        pin_d  = cell_d;
        pin_oe = quiet_oe;
      end
      DRV_ALL_OFF: begin
        pin_d  = func_d;
        pin_oe = 1'b0;
      end
      default: begin
        pin_d  = func_d;
        pin_oe = func_oe;
      end
    endcase
  end

  // Quiet clamp still takes data from the cell (R5).
  always_comb begin
    if (mode == DRV_SCAN_QUIET) begin
      p_quiet_data_r5: assert (pin_d == cell_d)
        else $error("quiet clamp data mismatch");
      if (TRISTATE)
        p_quiet_off_r5: assert (!pin_oe)
          else $error("quiet clamp left a three-state driver on");
    end
  end

endmodule

// File: rtl/bsc_out_ctrl.sv
module bsc_out_ctrl
  import bsc_pkg::*;
#(
  parameter int                     NUM_PINS      = 8,
  parameter logic [NUM_PINS-1:0]    TRISTATE_MASK = 8'h7F
) (
  input  logic                ir_extest,
  input  logic                ir_preload,
  input  logic                ir_clamp,
  input  logic                ir_highz,
  input  logic                ir_clampz,
  input  logic                chain0_sel,
  input  logic [NUM_PINS-1:0] func_data,
  input  logic [NUM_PINS-1:0] func_oe,
  input  logic [NUM_PINS-1:0] cell_data,
  input  logic [NUM_PINS-1:0] cell_oe,
  output logic [NUM_PINS-1:0] pin_data,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                highz_ind
);

  localparam int LastPin = NUM_PINS - 1;

  drv_mode_e mode;

  bsc_mode_decode u_decode (
    .ir_extest  (ir_extest),
    .ir_clamp   (ir_clamp),
    .ir_highz   (ir_highz),
    .ir_clampz  (ir_clampz),
    .chain0_sel (chain0_sel),
    .mode       (mode),
    .highz_ind  (highz_ind)
  );

  for (genvar i = 0; i <= LastPin; i++) begin : g_pin
    bsc_pin_ctrl #(
      .TRISTATE (TRISTATE_MASK[i])
    ) u_pin (
      .mode    (mode),
      .func_d  (func_data[i]),
      .func_oe (func_oe[i]),
      .cell_d  (cell_data[i]),
      .cell_oe (cell_oe[i]),
      .pin_d   (pin_data[i]),
      .pin_oe  (pin_oe[i])
    );
  end

  // Port-level checks across decoder and pin cells.
  always_comb begin
    if (highz_ind) begin
      p_highz_all_off_r4: assert (pin_oe == '0)
        else $error("driver on while indicator high");
      p_highz_source_r7: assert (ir_highz && chain0_sel)
        else $error("indicator high without high-Z on chain 0");
    end
    if (!chain0_sel && !ir_extest)
      p_off_chain_func_r6: assert (pin_data == func_data && pin_oe == func_oe)
        else $error("pins not functional off chain 0");
    if (ir_extest && !(chain0_sel && (ir_highz || ir_clampz)))
      p_extest_cells_r1: assert (pin_data == cell_data && pin_oe == cell_oe)
        else $error("external test pins not from cells");
    if (ir_preload && !ir_extest && !(chain0_sel && (ir_clamp || ir_highz || ir_clampz)))
      p_preload_func_r2: assert (pin_data == func_data && pin_oe == func_oe)
        else $error("preload leaked cell values");
  end

endmodule

// File: tb/test_bsc_out_ctrl.sv
module test_bsc_out_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  N          = 8;
  localparam logic [N-1:0] MASK = 8'h7F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_extest, ir_preload, ir_clamp, ir_highz, ir_clampz, chain0_sel;
  logic [N-1:0] func_data, func_oe, cell_data, cell_oe;
  logic [N-1:0] pin_data, pin_oe;
  logic highz_ind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_out_ctrl #(.NUM_PINS(N), .TRISTATE_MASK(MASK)) i_bsc_out_ctrl (
    .ir_extest(ir_extest), .ir_preload(ir_preload), .ir_clamp(ir_clamp),
    .ir_highz(ir_highz), .ir_clampz(ir_clampz), .chain0_sel(chain0_sel),
    .func_data(func_data), .func_oe(func_oe), .cell_data(cell_data),
    .cell_oe(cell_oe), .pin_data(pin_data), .pin_oe(pin_oe),
    .highz_ind(highz_ind)
  );

  task automatic chk(string req, logic [N-1:0] ed, logic [N-1:0] eo, logic eh);
    checks++;
    if (pin_data !== ed || pin_oe !== eo || highz_ind !== eh) begin
      errors++;
      $display("FAIL %s: data %h oe %h hz %b, expected data %h oe %h hz %b",
               req, pin_data, pin_oe, highz_ind, ed, eo, eh);
    end
  endtask

  task automatic set(logic ex, logic pr, logic cl, logic hz, logic cz, logic c0);
    @(negedge clk);
    {ir_extest, ir_preload, ir_clamp, ir_highz, ir_clampz, chain0_sel} = {ex, pr, cl, hz, cz, c0};
    #1;
  endtask

  task automatic t_reset_state;
    set(0, 0, 0, 0, 0, 0);
    chk("R2 idle", func_data, func_oe, 1'b0);
    set(0, 0, 0, 0, 0, 1);
    chk("R7 idle chain0", func_data, func_oe, 1'b0);
  endtask

  task automatic t_extest;
    set(1, 0, 0, 0, 0, 0);
    chk("R1 extest chain other", cell_data, cell_oe, 1'b0);
    set(1, 0, 0, 0, 0, 1);
    chk("R1 extest chain0", cell_data, cell_oe, 1'b0);
    @(negedge clk); cell_data = 8'h0F; cell_oe = 8'hF0; #1;
    chk("R1 extest new cells", 8'h0F, 8'hF0, 1'b0);
    @(negedge clk); cell_data = 8'h5A; cell_oe = 8'hC3; #1;
  endtask

  task automatic t_preload;
    set(0, 1, 0, 0, 0, 1);
    chk("R2 preload", func_data, func_oe, 1'b0);
  endtask

  task automatic t_clamp;
    set(0, 0, 1, 0, 0, 1);
    chk("R3 clamp chain0", cell_data, cell_oe, 1'b0);
    set(0, 0, 1, 0, 0, 0);
    chk("R6 clamp off chain", func_data, func_oe, 1'b0);
  endtask

  task automatic t_highz;
    set(0, 0, 0, 1, 0, 1);
    chk("R4 highz chain0", func_data, 8'h00, 1'b1);
    set(0, 0, 0, 1, 0, 0);
    chk("R6 R7 highz off chain", func_data, func_oe, 1'b0);
  endtask

  task automatic t_clampz;
    set(0, 0, 0, 0, 1, 1);
    chk("R5 clampz chain0", cell_data, cell_oe & ~MASK, 1'b0);
    set(0, 0, 0, 0, 1, 0);
    chk("R6 clampz off chain", func_data, func_oe, 1'b0);
  endtask

  task automatic t_priority;
    set(1, 0, 1, 1, 1, 1);
    chk("R8 highz first", func_data, 8'h00, 1'b1);
    set(1, 0, 1, 0, 1, 1);
    chk("R8 clampz over clamp", cell_data, cell_oe & ~MASK, 1'b0);
    set(1, 0, 1, 0, 0, 0);
    chk("R8 extest with gated clamp", cell_data, cell_oe, 1'b0);
    set(1, 1, 0, 1, 0, 0);
    chk("R8 extest over preload", cell_data, cell_oe, 1'b0);
  endtask

  task automatic t_comb;
    set(0, 0, 1, 0, 0, 1);
    @(negedge clk); cell_data = 8'hFF; #1;
    chk("R9 no clock wait", 8'hFF, cell_oe, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 held stable", 8'hFF, cell_oe, 1'b0);
    @(negedge clk); chain0_sel = 1'b0; #1;
    chk("R9 chain drop", func_data, func_oe, 1'b0);
    @(negedge clk); cell_data = 8'h5A; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    {ir_extest, ir_preload, ir_clamp, ir_highz, ir_clampz, chain0_sel} = '0;
    func_data = 8'hA5; func_oe = 8'h3C;
    cell_data = 8'h5A; cell_oe = 8'hC3;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_extest();
    t_preload();
    t_clamp();
    t_highz();
    t_clampz();
    t_priority();
    t_comb();
    func_data = 8'h3C; func_oe = 8'hFF;
    t_reset_state();
    t_highz();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule